// File: doc/BRIEF.md
# Three-Column Key Matrix Scanner

This block reads a small key matrix with three column lines and a set of active-low row inputs. A one-cycle start request, accepted only while the block is idle, clears the key bitmap and then visits column 0, column 1 and column 2 in turn. Each visit has two equal timed phases. In the first, every column line is driven high in push-pull mode so that the lines charge. In the second, all column drivers switch to open-drain and only the visited column is pulled low. On the last cycle of the second phase the synchronized rows are inverted, masked and placed into that column's slice of the bitmap.

Each phase lasts `CLK_MHZ * SETTLE_US` system clocks. Rows pass through a two-flop synchronizer first, so the phase must be at least three clocks long. When column 2 has been sampled, the block raises a one-cycle done pulse and sets a valid flag. The bitmap then holds still until the next start. While idle, all columns are left high in open-drain mode, so a press on any key can show up on the rows.

Top module: `kpd_scan`

## Requirements
- R1: After reset and while idle, `col_data` = 3'b111, `col_drain` = 3'b111 and `done` = 0. After reset, `key_map` = 0 and `map_valid` = 0.
- R2: A start pulse in idle makes `key_map` = 0 and `map_valid` = 0 in the next cycle. A start pulse during a scan has no effect on timing or result.
- R3: Columns are visited in ascending order 0, 1, 2. Each visit is a charge phase followed by a pull-low phase.
- R4: In the charge phase, `col_data` = 3'b111 and `col_drain` = 3'b000. The phase lasts D = CLK_MHZ*SETTLE_US cycles, and the first charge cycle is the cycle after the start edge.
- R5: In the pull-low phase, `col_drain` = 3'b111 and only bit c of `col_data` is 0, where c is the visited column. The phase lasts D cycles.
- R6: Bitmap bit c*ROWS+r is 1 exactly when `row_n[r]` was low, as seen through a two-flop synchronizer, on the last cycle of column c's pull-low phase, and `MASK` bit c*ROWS+r is 1.
- R7: `done` rises for exactly one cycle, in the cycle after the 6*D-th clock edge that follows the start edge. At the same time `map_valid` becomes 1.
- R8: Bitmap bits whose `MASK` bit is 0 are always 0. Once valid, `key_map` is stable until the next accepted start, whatever the rows do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | synchronous active-low reset |
| start | input | 1 | one-cycle scan request |
| row_n | input | ROWS | active-low row lines |
| col_data | output | 3 | column drive level per column |
| col_drain | output | 3 | 1 = column in open-drain mode, 0 = push-pull |
| done | output | 1 | one-cycle scan complete pulse |
| map_valid | output | 1 | key_map holds a completed scan |
| key_map | output | 3*ROWS | packed pressed-key bitmap |

## Verification
The bench uses a two-row configuration, which gives a six-key matrix. It drives every one of the 64 press patterns, and the row lines are computed from the columns the block actually pulls low. This sweep separates keys in different columns that share a row, catches a column taken in the wrong order, and catches a row sampled before the low level has reached it. A masked key position is part of every pattern, which shows that the mask removes that key and leaves its neighbours alone. Further runs repeat the start pulse partway through a scan, and change the presses after completion, to show that the held bitmap does not move.

// File: rtl/kpd_pkg.sv
// Shared types and constants for the key matrix scanner.
package kpd_pkg;
    localparam int NUM_COLS = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE  = 2'd1,
        ST_LOW  = 2'd2
    } kpd_state_e;
endpackage

// File: rtl/kpd_sync.sv
// Two-flop synchronizer for the asynchronous row lines.
// Assumes: rows idle high (no key), so reset loads all ones.
module kpd_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [W-1:0] meta;

    // Shift the inputs through two stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta  <= '1;
            d_out <= '1;
        end else begin
            meta  <= d_in;
            d_out <= meta;
        end
    end
endmodule

// File: rtl/kpd_delay.sv
// Phase timer: counts while run is high, flags the last cycle of each
// DLY-cycle phase and restarts by itself for the following phase.
// Assumes: DLY >= 1.
module kpd_delay #(
    parameter int DLY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic last
);
    localparam int CW = $clog2(DLY + 1);

    logic [CW-1:0] cnt;

    assign last = run && (cnt == CW'(DLY - 1));

    // Advance the count inside a phase, clear it at the phase end or when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt <= '0;
        else if (run && !last)     cnt <= cnt + 1'b1;
        else                       cnt <= '0;
    end

    // R4/R5: the count never passes the phase length
    a_r4_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CW'(DLY));
    // R4: a stopped timer restarts from zero
    a_r4_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt == '0);
endmodule

// File: rtl/kpd_pack.sv
// Turns one column's synchronized active-low rows into its masked slice
// of the key bitmap. The slice for column c starts at bit c*ROWS.
module kpd_pack #(
    parameter int                            ROWS = 4,
    parameter logic [kpd_pkg::NUM_COLS*ROWS-1:0] MASK = '1
) (
    input  logic [ROWS-1:0]                   rows_n,
    input  logic [1:0]                        col,
    output logic [kpd_pkg::NUM_COLS*ROWS-1:0] bits
);
    localparam int KEYS = kpd_pkg::NUM_COLS * ROWS;

    logic [ROWS-1:0] act;
    logic [KEYS-1:0] part [kpd_pkg::NUM_COLS];

    assign act = ~rows_n;

    for (genvar c = 0; c < kpd_pkg::NUM_COLS; c++) begin : g_col
        assign part[c] = (col == 2'(c)) ? ((KEYS'(act) << (c * ROWS)) & MASK) : '0;
    end

    // Merge the column slices (only the selected one is non-zero).
    always_comb begin
        bits = '0;
        for (int c = 0; c < kpd_pkg::NUM_COLS; c++) bits = bits | part[c];
    end
endmodule

// File: rtl/kpd_scan.sv
// Key matrix scanner, top level. When started, visits columns 0..2. Each
// visit charges all columns high (push-pull) for DLY clocks, then switches
// to open-drain with only the visited column low for DLY clocks, and
// samples the rows on the last of those clocks.
// Assumes: DLY = CLK_MHZ*SETTLE_US >= 3 so that the synchronized rows
// reflect the low column at sampling time; start is a one-cycle pulse.
module kpd_scan #(
    parameter int                       ROWS      = 4,
    parameter int                       CLK_MHZ   = 50,
    parameter int                       SETTLE_US = 2,
    parameter logic [3*ROWS-1:0]        MASK      = '1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [ROWS-1:0]      row_n,
    output logic [2:0]           col_data,
    output logic [2:0]           col_drain,
    output logic                 done,
    output logic                 map_valid,
    output logic [3*ROWS-1:0]    key_map
);
    import kpd_pkg::*;

    localparam int DLY  = CLK_MHZ * SETTLE_US;
    localparam int KEYS = NUM_COLS * ROWS;
    localparam logic [1:0] LAST_COL = 2'(NUM_COLS - 1);

    kpd_state_e      state;
    logic [1:0]      col_idx;
    logic            last;
    logic [ROWS-1:0] rows_s;
    logic [KEYS-1:0] slice;

    kpd_sync #(.W(ROWS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (row_n),
        .d_out (rows_s)
    );

    kpd_delay #(.DLY(DLY)) u_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state != ST_IDLE),
        .last  (last)
    );

    kpd_pack #(.ROWS(ROWS), .MASK(MASK)) u_pack (
        .rows_n (rows_s),
        .col    (col_idx),
        .bits   (slice)
    );

    // Column driver settings for the current phase.
    always_comb begin
        col_data  = 3'b111;
        col_drain = 3'b111;
        if (state == ST_PRE) begin
            col_drain = 3'b000;
        end else if (state == ST_LOW) begin
            col_data = ~(3'b001 << col_idx);
        end
    end

    // Scan sequencer: phase stepping, bitmap accumulation, completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            col_idx   <= '0;
            done      <= 1'b0;
            map_valid <= 1'b0;
            key_map   <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    state     <= ST_PRE;
                    col_idx   <= '0;
                    key_map   <= '0;
                    map_valid <= 1'b0;
                end
                ST_PRE: if (last) state <= ST_LOW;
                ST_LOW: if (last) begin
                    key_map <= key_map | slice;
                    if (col_idx == LAST_COL) begin
                        state     <= ST_IDLE;
                        done      <= 1'b1;
                        map_valid <= 1'b1;
                    end else begin
                        col_idx <= col_idx + 1'b1;
                        state   <= ST_PRE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R1: idle leaves every column high in open-drain mode
    a_r1_idle_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (col_data == 3'b111 && col_drain == 3'b111));
    // R2: an accepted start clears the bitmap and the valid flag
    a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start) |=> (key_map == '0 && !map_valid));
    // R3: within a scan the column index only steps upward by one
    a_r3_col_order: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && $past(state) != ST_IDLE && col_idx != $past(col_idx))
        |-> col_idx == $past(col_idx) + 2'd1);
    // R5: open-drain phase pulls at most one column low
    a_r5_one_low: assert property (@(posedge clk) disable iff (!rst_n)
        (col_drain == 3'b111) |-> $countones(~col_data) <= 1);
    // R7: done lasts a single cycle
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R8: masked keys never appear
    a_r8_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (key_map & ~MASK) == '0);
    // R8: a valid bitmap holds until a new start
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (map_valid && !start) |=> $stable(key_map));
endmodule

// File: tb/kpd_scan_bench.sv
// Bench: six-key matrix (ROWS=2), phase of 4 clocks, one masked key.
module kpd_scan_bench;
    localparam int          ROWS = 2;
    localparam int          D    = 4;
    localparam int          KEYS = 3 * ROWS;
    localparam logic [5:0]  MSK  = 6'b101111;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [ROWS-1:0] row_n;
    logic [2:0]      col_data, col_drain;
    logic            done, map_valid;
    logic [KEYS-1:0] key_map;
    logic [KEYS-1:0] pressed = '0;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    kpd_scan #(.ROWS(ROWS), .CLK_MHZ(2), .SETTLE_US(2), .MASK(MSK)) u_kpd_scan (
        .clk(clk), .rst_n(rst_n), .start(start), .row_n(row_n),
        .col_data(col_data), .col_drain(col_drain), .done(done),
        .map_valid(map_valid), .key_map(key_map)
    );

    always #10 clk = ~clk;

    // Matrix model: a row reads low when a pressed key joins it to a low column.
    always_comb begin
        for (int r = 0; r < ROWS; r++) begin
            row_n[r] = 1'b1;
            for (int c = 0; c < 3; c++)
                if (pressed[c*ROWS+r] && !col_data[c]) row_n[r] = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One scan; extra_at >= 0 repeats start at that cycle index (R2).
    task automatic run_scan(input logic [KEYS-1:0] pat, input int extra_at);
        int n;
        bit seq_ok;
        logic [2:0] exp_d, exp_o;
        pressed = pat;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(key_map == 0 && !map_valid, "R2 clear", int'(key_map), 0);
        n = 0;
        seq_ok = 1'b1;
        while (!done && n <= 6*D + 4) begin
            int p;
            p = n / D;
            exp_o = (p % 2 == 1) ? 3'b111 : 3'b000;
            exp_d = (p % 2 == 1) ? ~(3'b001 << (p / 2)) : 3'b111;
            if (col_data != exp_d || col_drain != exp_o) seq_ok = 1'b0;
            @(negedge clk);
            start = (n + 1 == extra_at);
            n++;
        end
        start = 1'b0;
        chk(seq_ok, "R3 R4 R5 drive sequence", int'(col_data), int'(exp_d));
        chk(n == 6*D, "R7 done timing", n, 6*D);
        chk(done && map_valid, "R7 valid", int'(map_valid), 1);
        chk(key_map == (pat & MSK), "R6 R8 bitmap", int'(key_map), int'(pat & MSK));
        @(negedge clk);
        chk(!done, "R7 one-cycle done", int'(done), 0);
    endtask

    // Watchdog.
    initial begin
        while (cycles < 200000) begin
            @(posedge clk);
            cycles++;
        end
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected<200000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [KEYS-1:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(col_data == 3'b111 && col_drain == 3'b111 && !done,
            "R1 idle drive", int'({col_data, col_drain}), 63);
        chk(key_map == 0 && !map_valid, "R1 reset map", int'(key_map), 0);

        // Exhaustive press patterns (R6, R3 order via slice position).
        for (int k = 0; k < 64; k++) run_scan(KEYS'(k), -1);

        // R2: start during a scan is ignored.
        run_scan(6'b010110, 5);
        run_scan(6'b101001, 3*D + 1);

        // R8: bitmap held while rows change; R1 idle drive after scan.
        held = key_map;
        pressed = ~pressed;
        repeat (5) @(negedge clk);
        chk(key_map == held && map_valid, "R8 hold", int'(key_map), int'(held));
        chk(col_data == 3'b111 && col_drain == 3'b111, "R1 idle after scan",
            int'({col_data, col_drain}), 63);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule